// File: doc/BRIEF.md
# Holdover Frequency Word Store

This block keeps copies of a digital loop's frequency control word so that the output clock can keep running at the right rate after the reference is lost. While the loop reports lock and no holdover is requested, a counter driven by a one-millisecond tick marks out fixed sampling periods, 30 ms by default. At the end of each period the current frequency word is written into one of two registers, and successive samples go to the two registers in turn.

The output always presents the older of the two stored samples. That word was captured between one and two periods earlier, so a disturbance in the last moments before the reference failed never reaches the holdover frequency. Until two samples exist since the most recent lock acquisition, the valid flag stays low and the output carries a fixed nominal centre word. While holdover is requested, sampling stops and both registers keep their contents.

Top module: `hfw_store`

## Requirements
- R1: After reset, `hold_valid` is 0 and `hold_word` equals the parameter `NOMINAL_WORD`.
- R2: A sample is taken only on a clock edge where `locked` is 1 and `hold_req` is 0; with `locked` at 0 neither output changes.
- R3: The sampling period is `PERIOD_MS` rising `ms_tick` cycles (30 by default), counted in ticks, not in clock cycles; a sample is stored on the edge that carries the `PERIOD_MS`-th tick.
- R4: Successive samples alternate between two registers, so each new sample replaces the one taken two periods earlier.
- R5: When `hold_valid` is 1, `hold_word` is the second-newest sample, not the newest, and it changes one cycle after the sampling edge.
- R6: While `hold_req` is 1, both registers and the period count are frozen; after release the count resumes from where it stopped.
- R7: While `locked` is 0 the period count is held at zero, so a partial period before a lock loss is discarded.
- R8: `hold_valid` goes to 0 on the edge where `locked` rises and goes to 1 only once two samples have been stored since then; a lock loss alone does not clear it.
- R9: Whenever `hold_valid` is 0, `hold_word` equals `NOMINAL_WORD`, also while `hold_req` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| locked | input | 1 | Loop is in normal mode and locked |
| hold_req | input | 1 | Holdover requested |
| freq_word | input | WORD_W | Current frequency control word |
| hold_word | output | WORD_W | Word to use during holdover |
| hold_valid | output | 1 | Two samples exist since the last lock acquisition |

## Verification
The word input changes to a distinct value in every period, so the output shows which sample it holds: the newest, the older one, or one from the wrong register. Ticks are given both on every cycle and on every third cycle, which separates a counter that counts ticks from one that counts clock cycles. A partial period followed by a holdover request and then a release shows whether the count freezes or restarts. A partial period cut short by a lock loss, followed by a relock, shows whether the count is cleared and whether the valid flag is reset on the rising edge of lock.

// File: rtl/hfw_pkg.sv
package hfw_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_HALF  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_e;

    function automatic fill_e fill_step(input fill_e cur);
        case (cur)
            FILL_EMPTY: fill_step = FILL_HALF;
            default:    fill_step = FILL_FULL;
        endcase
    endfunction

endpackage

// File: rtl/hfw_period_timer.sv
module hfw_period_timer #(
    parameter int PERIOD_MS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic clear,
    output logic fire
);
    localparam int CNT_W = (PERIOD_MS > 1) ? $clog2(PERIOD_MS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_MS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        fire  = 1'b0;
        if (clear) begin
            tmr_d.cnt = '0;
        end else if (run && tick) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.cnt = '0;
                fire      = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/hfw_pingpong_bank.sv
module hfw_pingpong_bank
    import hfw_pkg::*;
#(
    parameter int          WORD_W     = 32,
    parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              restart,
    output logic [WORD_W-1:0] older_word,
    output fill_e             fill
);
    localparam int SLOTS = 2;

    typedef struct packed {
        logic [SLOTS-1:0][WORD_W-1:0] slot;
        logic                         ptr;
        fill_e                        fill;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [SLOTS-1:0] slot_we;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot_we
        assign slot_we[g] = wr_en && (bank_q.ptr == 1'(g));
    end

    always_comb begin
        bank_d = bank_q;
        for (int s = 0; s < SLOTS; s++) begin
            if (slot_we[s]) bank_d.slot[s] = wr_data;
        end
        if (restart) begin
            bank_d.fill = FILL_EMPTY;
        end else if (wr_en) begin
            bank_d.fill = fill_step(bank_q.fill);
        end
        if (wr_en) bank_d.ptr = ~bank_q.ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.slot <= {SLOTS{RESET_WORD}};
            bank_q.ptr  <= 1'b0;
            bank_q.fill <= FILL_EMPTY;
        end else begin
            bank_q <= bank_d;
        end
    end

    // The slot about to be overwritten holds the older sample.
    assign older_word = bank_q.slot[bank_q.ptr];
    assign fill       = bank_q.fill;

endmodule

// File: rtl/hfw_store.sv
module hfw_store
    import hfw_pkg::*;
#(
    parameter int                WORD_W       = 32,
    parameter int                PERIOD_MS    = 30,
    parameter logic [WORD_W-1:0] NOMINAL_WORD = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              locked,
    input  logic              hold_req,
    input  logic [WORD_W-1:0] freq_word,
    output logic [WORD_W-1:0] hold_word,
    output logic              hold_valid
);
    typedef struct packed {
        logic locked_prev;
    } top_t;

    top_t top_d, top_q;
    logic lock_rise;
    logic take_sample;
    logic [WORD_W-1:0] older_word;
    fill_e fill;

    always_comb begin
        top_d             = top_q;
        top_d.locked_prev = locked;
        lock_rise         = locked && !top_q.locked_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    hfw_period_timer #(
        .PERIOD_MS(PERIOD_MS)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (ms_tick),
        .run  (locked && !hold_req),
        .clear(!locked),
        .fire (take_sample)
    );

    hfw_pingpong_bank #(
        .WORD_W    (WORD_W),
        .RESET_WORD(NOMINAL_WORD)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (take_sample),
        .wr_data   (freq_word),
        .restart   (lock_rise),
        .older_word(older_word),
        .fill      (fill)
    );

    assign hold_valid = (fill == FILL_FULL);
    assign hold_word  = hold_valid ? older_word : NOMINAL_WORD;

endmodule

// File: rtl/hfw_store_chk.sv
module hfw_store_chk #(
    parameter int                WORD_W       = 32,
    parameter logic [WORD_W-1:0] NOMINAL_WORD = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ms_tick,
    input logic              locked,
    input logic              hold_req,
    input logic [WORD_W-1:0] hold_word,
    input logic              hold_valid
);
    assert_nominal_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_valid |-> hold_word == NOMINAL_WORD);

    assert_unlocked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> ($stable(hold_word) && $stable(hold_valid)));

    assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req && !$rose(locked)) |=> ($stable(hold_word) && $stable(hold_valid)));

    assert_tick_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick && !$rose(locked)) |=> ($stable(hold_word) && $stable(hold_valid)));

    assert_valid_from_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_valid) |-> ($past(locked) && !$past(hold_req) && $past(ms_tick)));

endmodule

bind hfw_store hfw_store_chk #(
    .WORD_W      (WORD_W),
    .NOMINAL_WORD(NOMINAL_WORD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .locked    (locked),
    .hold_req  (hold_req),
    .hold_word (hold_word),
    .hold_valid(hold_valid)
);

// File: tb/sim_hfw_store.sv
module sim_hfw_store;
    localparam int          W   = 32;
    localparam int          PER = 30;
    localparam logic [W-1:0] NOM = 32'h4000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ms_tick = 1'b0;
    logic         locked = 1'b0;
    logic         hold_req = 1'b0;
    logic [W-1:0] freq_word = '0;
    logic [W-1:0] hold_word;
    logic         hold_valid;

    always #2.5 clk = ~clk;

    hfw_store #(.WORD_W(W), .PERIOD_MS(PER), .NOMINAL_WORD(NOM)) u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .locked(locked),
        .hold_req(hold_req), .freq_word(freq_word),
        .hold_word(hold_word), .hold_valid(hold_valid)
    );

    typedef struct {
        logic [W-1:0] word;
        logic         valid;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state: history of the two newest samples
    logic [W-1:0] m_new, m_old;
    int           m_count, m_cnt;
    bit           m_prev_lk;

    task automatic check(input logic [W-1:0] aw, input logic av,
                         input logic [W-1:0] ew, input logic ev, input string tag);
        checks++;
        if (aw !== ew || av !== ev) begin
            errors++;
            $display("FAIL %s: word=%h valid=%b expected word=%h valid=%b",
                     tag, aw, av, ew, ev);
        end
    endtask

    task automatic run(input int n, input int div, input bit lk, input bit hr,
                       input logic [W-1:0] w, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            bit tk;
            @(negedge clk);
            tk = ((i % div) == div - 1);
            ms_tick = tk; locked = lk; hold_req = hr; freq_word = w;
            if (lk && !m_prev_lk) m_count = 0;
            if (!lk) m_cnt = 0;
            else if (!hr && tk) begin
                m_cnt++;
                if (m_cnt == PER) begin
                    m_cnt = 0;
                    m_old = m_new;
                    m_new = w;
                    if (m_count < 2) m_count++;
                end
            end
            m_prev_lk = lk;
            e.valid = (m_count >= 2);
            e.word  = e.valid ? m_old : NOM;
            e.tag   = tag;
            @(posedge clk);
            exp_q.push_back(e);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(hold_word, hold_valid, e.word, e.valid, e.tag);
            end
        end
    end

    initial begin
        m_new = NOM; m_old = NOM; m_count = 0; m_cnt = 0; m_prev_lk = 0;
        #1;
        check(hold_word, hold_valid, NOM, 1'b0, "R1 in reset");
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(hold_word, hold_valid, NOM, 1'b0, "R1 after reset");
        run(6, 1, 0, 0, 32'h1111_0001, "R2 unlocked idle");
        run(PER, 1, 1, 0, 32'hA000_000A, "R9 one sample");
        run(PER, 1, 1, 0, 32'hB000_000B, "R5 older shown");
        run(PER, 1, 1, 0, 32'hC000_000C, "R4 ping-pong");
        run(3 * PER, 3, 1, 0, 32'hD000_000D, "R3 tick counting");
        run(10, 1, 1, 0, 32'h5555_0005, "R6 partial before hold");
        run(100, 1, 1, 1, 32'hE000_000E, "R6 hold frozen");
        run(PER - 10, 1, 1, 0, 32'h6000_0006, "R6 resume count");
        run(15, 1, 1, 0, 32'h7000_0007, "R7 partial before loss");
        run(5, 1, 0, 0, 32'h7100_0007, "R2 lock lost");
        run(PER, 1, 1, 0, 32'h8000_0008, "R8 relock clears");
        run(10, 1, 1, 1, 32'h8100_0008, "R9 hold while invalid");
        run(PER, 1, 1, 0, 32'h9000_0009, "R7 count restarted");
        run(PER, 1, 1, 0, 32'h9100_0009, "R8 valid again");
        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule